// File: doc/BRIEF.md
# Byte-Wide Slave Configuration Loader

This block lets a host load a bitstream into a target FPGA over the target's byte-wide slave configuration port. Configuration bytes come in from an upstream source through a valid/ready handshake, with a flag that marks the final byte. The block pulses the target's program line low and waits for the target to finish clearing its configuration memory. It then streams the bytes with a configuration clock that it derives from the system clock, and keeps clocking filler bytes until the target reports completion.

The target numbers its data pins the opposite way from the host, so every byte is bit-reversed before it is driven. The target's BUSY line can throttle the stream: while BUSY is high at a clock edge, the current byte is held and clocked again. An init line that falls during the transfer is reported as a CRC error. A bound on the number of filler bytes turns a target that never finishes into a timeout. A start pulse begins a run from idle or from any final state.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset, the outputs are as follows. `tgt_prog_b` is high, `tgt_cs_b` is high, `tgt_cclk` is low and `tgt_rdwr_b` is low. `run_busy`, `done_ok`, `crc_error` and `timeout` are all low.
- R2: A `start` pulse drives `tgt_prog_b` low for exactly PROG_CYCLES system clocks, then releases it high. `tgt_cs_b` stays high while `tgt_prog_b` is low.
- R3: No configuration clock edge and no chip select occur until `tgt_init_b` has been seen low and then high again.
- R4: An accepted input byte b is driven as `tgt_d[k] = b[7-k]`, so pin 0 carries the most significant bit. Bytes reach the target once each, in input order, captured on the rising `tgt_cclk` edge while `tgt_cs_b` is low. `in_ready` is high only while `tgt_cclk` is low.
- R5: `tgt_cclk` has a period of 2*CLK_HALF system clocks. `tgt_d` changes, and `tgt_cs_b` falls, only while `tgt_cclk` is low.
- R6: With USE_BUSY set, if `tgt_busy` is high at a rising `tgt_cclk` edge, the same byte is presented and clocked again on the next edge. No byte is lost or duplicated.
- R7: After the final byte, 8'hFF filler bytes are clocked until `tgt_done` is seen high. The run then ends with `done_ok` high and `tgt_cs_b` high.
- R8: At most PAD_LIMIT filler bytes are clocked. If `tgt_done` is still low when the next filler slot arrives, the run ends with `timeout` high.
- R9: A low `tgt_init_b` during streaming or filling ends the run with `crc_error` high. `tgt_cs_b` is then high and `tgt_cclk` low from the next cycle, and no further bytes are captured.
- R10: `done_ok`, `crc_error` and `timeout` are mutually exclusive and low while `run_busy` is high. Each holds until the next `start`, which clears it and sets `run_busy`.
- R11: If no input byte is valid at a byte slot, `tgt_cs_b` is high for that configuration clock and the target captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a configuration run from idle or a final state |
| in_data | input | 8 | Configuration byte, most significant bit first |
| in_valid | input | 1 | in_data holds a byte |
| in_last | input | 1 | The byte is the final one of the stream |
| in_ready | output | 1 | The byte is taken on this clock |
| tgt_prog_b | output | 1 | Target program line, active low |
| tgt_cs_b | output | 1 | Target chip select, active low |
| tgt_rdwr_b | output | 1 | Target direction, held low for write |
| tgt_cclk | output | 1 | Target configuration clock |
| tgt_d | output | 8 | Target data pins, bit-reversed |
| tgt_init_b | input | 1 | Target init line, asynchronous |
| tgt_done | input | 1 | Target completion line, asynchronous |
| tgt_busy | input | 1 | Target throttle line, asynchronous |
| run_busy | output | 1 | A run is in progress |
| done_ok | output | 1 | The last run completed |
| crc_error | output | 1 | The last run ended with init low |
| timeout | output | 1 | The last run exhausted the filler budget |

## Verification
Some properties are checked on every cycle. Data and chip select move only in the low half of the configuration clock. The handshake opens only in that half. Chip select stays high during the program pulse. The status flags exclude one another, and an error freezes the port. Other behaviour only the scenarios can show, by observing a behavioural target at its pins. These are the exact program pulse length, the clock period and the absence of early edges. They also cover in-order bit-reversed delivery across stream gaps, and re-clocking of a byte refused under BUSY. The last group is the filler count that ends in success or timeout, and CRC aborts both in the stream and in the filler phase.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_PROG, S_WAIT_LO, S_WAIT_HI, S_STREAM, S_PAD, S_OK, S_CRC, S_TMO
    } ld_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       cs_n;
    } port_drive_t;

    localparam logic [7:0] FILL_BYTE = 8'hFF;

    function automatic logic [7:0] flip8(input logic [7:0] b);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = b[7-k];
        return r;
    endfunction

endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
            end else begin
                meta_q <= din[g];
                stab_q <= meta_q;
            end
        end
        assign dout[g] = stab_q;
    end
endmodule

// File: rtl/cfgld_cclk_gen.sv
module cfgld_cclk_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic cclk,
    output logic slot,
    output logic pre_rise
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          cclk_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q  <= '0;
            cclk_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            cclk_q <= ~cclk_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cclk     = cclk_q;
    assign slot     = en && !cclk_q && (cnt_q == '0);
    assign pre_rise = en && !cclk_q && (cnt_q == LAST);
endmodule

// File: rtl/cfgld_timer.sv
module cfgld_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;
    always_ff @(posedge clk) begin
        if (rst)                   cnt_q <= '0;
        else if (load)             cnt_q <= load_val;
        else if (dec && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end
    assign zero = (cnt_q == '0);
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
    import cfgld_pkg::*;
#(
    parameter int CLK_HALF    = 4,
    parameter int PROG_CYCLES = 16,
    parameter int PAD_LIMIT   = 8,
    parameter bit USE_BUSY    = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic       tgt_prog_b,
    output logic       tgt_cs_b,
    output logic       tgt_rdwr_b,
    output logic       tgt_cclk,
    output logic [7:0] tgt_d,
    input  logic       tgt_init_b,
    input  logic       tgt_done,
    input  logic       tgt_busy,
    output logic       run_busy,
    output logic       done_ok,
    output logic       crc_error,
    output logic       timeout
);
    localparam int PROG_W = $clog2(PROG_CYCLES + 1);
    localparam int PAD_W  = $clog2(PAD_LIMIT + 1);

    ld_state_t   state_q, state_d;
    port_drive_t drive_q, drive_d;
    logic        retry_q;
    logic        init_s, done_s, busy_s, busy_gate;
    logic        clk_en, slot, pre_rise;
    logic        prog_load, prog_dec, prog_zero;
    logic        pad_load, pad_dec, pad_zero;
    logic        can_start, arm;

    cfgld_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({tgt_busy, tgt_done, tgt_init_b}),
        .dout({busy_s, done_s, init_s})
    );

    if (USE_BUSY) begin : g_busy_on
        assign busy_gate = busy_s;
    end else begin : g_busy_off
        assign busy_gate = 1'b0;
    end

    assign clk_en = (state_q == S_STREAM) || (state_q == S_PAD);

    cfgld_cclk_gen #(.HALF(CLK_HALF)) u_cclk (
        .clk     (clk),
        .rst     (rst),
        .en      (clk_en),
        .cclk    (tgt_cclk),
        .slot    (slot),
        .pre_rise(pre_rise)
    );

    cfgld_timer #(.W(PROG_W)) u_prog_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (prog_load),
        .load_val(PROG_W'(PROG_CYCLES - 1)),
        .dec     (prog_dec),
        .zero    (prog_zero)
    );

    cfgld_timer #(.W(PAD_W)) u_pad_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (pad_load),
        .load_val(PAD_W'(PAD_LIMIT)),
        .dec     (pad_dec),
        .zero    (pad_zero)
    );

    assign can_start = (state_q == S_IDLE) || (state_q == S_OK) ||
                       (state_q == S_CRC)  || (state_q == S_TMO);
    assign arm       = can_start && start;
    assign in_ready  = (state_q == S_STREAM) && slot && !retry_q && init_s;

    always_comb begin
        state_d   = state_q;
        drive_d   = drive_q;
        prog_load = 1'b0;
        prog_dec  = 1'b0;
        pad_load  = 1'b0;
        pad_dec   = 1'b0;
        case (state_q)
            S_IDLE, S_OK, S_CRC, S_TMO: begin
                if (start) begin
                    state_d   = S_PROG;
                    prog_load = 1'b1;
                end
            end
            S_PROG: begin
                if (prog_zero) state_d = S_WAIT_LO;
                else           prog_dec = 1'b1;
            end
            S_WAIT_LO: if (!init_s) state_d = S_WAIT_HI;
            S_WAIT_HI: if (init_s)  state_d = S_STREAM;
            S_STREAM: begin
                if (!init_s) begin
                    state_d      = S_CRC;
                    drive_d.cs_n = 1'b1;
                end else if (slot && !retry_q) begin
                    if (in_valid) begin
                        drive_d = '{data: flip8(in_data), cs_n: 1'b0};
                        if (in_last) begin
                            state_d  = S_PAD;
                            pad_load = 1'b1;
                        end
                    end else begin
                        drive_d.cs_n = 1'b1;
                    end
                end
            end
            S_PAD: begin
                if (!init_s) begin
                    state_d      = S_CRC;
                    drive_d.cs_n = 1'b1;
                end else if (done_s) begin
                    state_d      = S_OK;
                    drive_d.cs_n = 1'b1;
                end else if (slot && !retry_q) begin
                    if (pad_zero) begin
                        state_d      = S_TMO;
                        drive_d.cs_n = 1'b1;
                    end else begin
                        drive_d = '{data: FILL_BYTE, cs_n: 1'b0};
                        pad_dec = 1'b1;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            drive_q <= '{data: 8'h00, cs_n: 1'b1};
            retry_q <= 1'b0;
        end else begin
            state_q <= state_d;
            drive_q <= drive_d;
            if (arm)           retry_q <= 1'b0;
            else if (pre_rise) retry_q <= busy_gate && !drive_q.cs_n;
        end
    end

    assign tgt_prog_b = (state_q != S_PROG);
    assign tgt_cs_b   = drive_q.cs_n;
    assign tgt_d      = drive_q.data;
    assign tgt_rdwr_b = 1'b0;
    assign run_busy   = !can_start;
    assign done_ok    = (state_q == S_OK);
    assign crc_error  = (state_q == S_CRC);
    assign timeout    = (state_q == S_TMO);
endmodule

// File: rtl/cfgld_checks.sv
module cfgld_checks (
    input logic       clk,
    input logic       rst,
    input logic       tgt_cclk,
    input logic       tgt_cs_b,
    input logic [7:0] tgt_d,
    input logic       tgt_prog_b,
    input logic       in_ready,
    input logic       run_busy,
    input logic       done_ok,
    input logic       crc_error,
    input logic       timeout
);
    p_data_moves_low_r5: assert property (@(posedge clk) disable iff (rst)
        (tgt_d != $past(tgt_d)) |-> !tgt_cclk);

    p_select_falls_low_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(tgt_cs_b) |-> !tgt_cclk);

    p_ready_in_low_half_r4: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !tgt_cclk);

    p_prog_deselect_r2: assert property (@(posedge clk) disable iff (rst)
        !tgt_prog_b |-> tgt_cs_b);

    p_status_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_ok, crc_error, timeout}));

    p_busy_no_status_r10: assert property (@(posedge clk) disable iff (rst)
        run_busy |-> !(done_ok || crc_error || timeout));

    p_crc_freezes_port_r9: assert property (@(posedge clk) disable iff (rst)
        crc_error |=> (tgt_cs_b && !tgt_cclk));
endmodule

bind fpga_cfg_loader cfgld_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .tgt_cclk  (tgt_cclk),
    .tgt_cs_b  (tgt_cs_b),
    .tgt_d     (tgt_d),
    .tgt_prog_b(tgt_prog_b),
    .in_ready  (in_ready),
    .run_busy  (run_busy),
    .done_ok   (done_ok),
    .crc_error (crc_error),
    .timeout   (timeout)
);

// File: tb/tb_fpga_cfg_loader.sv
module tb_fpga_cfg_loader;
    localparam int HALF  = 4;
    localparam int PROGC = 10;
    localparam int PADL  = 6;

    // {nbytes[26:19], gap[18], done_after[17:10], crc_at[9:2], expect[1:0]}
    // expect: 0 = done_ok, 1 = crc_error, 2 = timeout
    localparam logic [26:0] CASES [0:5] = '{
        {8'd4, 1'b0, 8'd2, 8'd0, 2'd0},
        {8'd6, 1'b1, 8'd1, 8'd0, 2'd0},
        {8'd3, 1'b0, 8'd0, 8'd0, 2'd2},
        {8'd2, 1'b0, 8'd6, 8'd0, 2'd0},
        {8'd5, 1'b0, 8'd0, 8'd3, 2'd1},
        {8'd2, 1'b0, 8'd0, 8'd4, 2'd1}
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_valid = 1'b0, in_last = 1'b0, in_ready;
    logic tgt_prog_b, tgt_cs_b, tgt_rdwr_b, tgt_cclk;
    logic [7:0] tgt_d;
    logic tgt_init_b = 1'b1, tgt_done = 1'b0, tgt_busy = 1'b0;
    logic run_busy, done_ok, crc_error, timeout;

    always #4 clk = ~clk;

    fpga_cfg_loader #(.CLK_HALF(HALF), .PROG_CYCLES(PROGC), .PAD_LIMIT(PADL), .USE_BUSY(1'b1)) dut (
        .clk(clk), .rst(rst), .start(start), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .tgt_prog_b(tgt_prog_b), .tgt_cs_b(tgt_cs_b),
        .tgt_rdwr_b(tgt_rdwr_b), .tgt_cclk(tgt_cclk), .tgt_d(tgt_d), .tgt_init_b(tgt_init_b),
        .tgt_done(tgt_done), .tgt_busy(tgt_busy), .run_busy(run_busy), .done_ok(done_ok),
        .crc_error(crc_error), .timeout(timeout)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = b[7-k];
        return r;
    endfunction

    function automatic logic [7:0] pat(input int c, input int i);
        return 8'(i * 37 + c * 11 + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural target
    int stream_len = 0, done_after = 0, crc_at = 0;
    int cap_n = 0, pads = 0, blocked = 0, early = 0, prog_len = 0, rcount = 0;
    int rise_c0 = 0, rise_c1 = 0;
    logic [7:0] cap_log [0:63];
    logic [7:0] raw_first = 8'h00;
    bit pre_init = 1'b0, busy_en = 1'b0;
    int fcnt = 0;

    always @(negedge tgt_prog_b) begin
        tgt_init_b = 1'b0;
        tgt_done   = 1'b0;
        pre_init   = 1'b1;
    end
    always @(posedge tgt_prog_b) begin
        if (!rst) begin
            repeat (12) @(posedge clk);
            tgt_init_b = 1'b1;
            pre_init   = 1'b0;
        end
    end
    always @(posedge clk) if (!rst && !tgt_prog_b) prog_len++;

    always @(posedge tgt_cclk) begin
        if (pre_init) early++;
        if (rcount == 0) rise_c0 = cyc;
        if (rcount == 1) rise_c1 = cyc;
        rcount++;
        if (!tgt_cs_b) begin
            if (tgt_busy) blocked++;
            else begin
                if (cap_n == 0) raw_first = tgt_d;
                if (cap_n < 64) cap_log[cap_n] = rev8(tgt_d);
                cap_n++;
                if (cap_n > stream_len) begin
                    pads++;
                    if (done_after != 0 && pads == done_after) tgt_done = 1'b1;
                end
                if (crc_at != 0 && cap_n == crc_at) tgt_init_b = 1'b0;
            end
        end
    end

    always @(negedge tgt_cclk) begin
        if (busy_en) begin
            fcnt++;
            tgt_busy <= (fcnt % 3 == 1);
        end else begin
            tgt_busy <= 1'b0;
        end
    end

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (R7): actual hung expected finished");
        summary_and_end();
    end

    task automatic run_case(input int c, input int nb, input bit gap, input int dafter,
                            input int crcat, input int expect_code);
        int mism;
        stream_len = nb; done_after = dafter; crc_at = crcat;
        cap_n = 0; pads = 0; blocked = 0; early = 0; prog_len = 0; rcount = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(run_busy && !done_ok && !crc_error && !timeout, "R10 rearm", run_busy, 1);
        for (int i = 0; i < nb; i++) begin
            in_valid = 1'b1; in_data = pat(c, i); in_last = (i == nb - 1);
            while (!in_ready && run_busy) @(negedge clk);
            if (!run_busy) break;
            @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0;
            if (gap) repeat (9) @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
        while (run_busy) @(negedge clk);
        repeat (12) @(negedge clk);
        mism = 0;
        if (expect_code == 1) begin
            check(crc_error && !done_ok && !timeout, "R9 crc flag", crc_error, 1);
            check(cap_n == crcat, "R9 capture frozen", cap_n, crcat);
            check(tgt_cs_b && !tgt_cclk, "R9 port idle", {tgt_cs_b, tgt_cclk}, 2);
        end else begin
            for (int i = 0; i < nb; i++) if (cap_log[i] !== pat(c, i)) mism++;
            for (int i = nb; i < cap_n && i < 64; i++) if (cap_log[i] !== 8'hFF) mism++;
            check(mism == 0, gap ? "R11 gapped order" : "R4 order and reversal", mism, 0);
            if (expect_code == 0) begin
                check(done_ok && !crc_error && !timeout, "R7 done flag", done_ok, 1);
                check(pads == dafter, "R7 filler count", pads, dafter);
            end else begin
                check(timeout && !done_ok && !crc_error, "R8 timeout flag", timeout, 1);
                check(pads == PADL, "R8 filler limit", pads, PADL);
            end
            check(tgt_cs_b == 1'b1, "R7 deselect at end", tgt_cs_b, 1);
        end
        check(prog_len == PROGC, "R2 program pulse", prog_len, PROGC);
        check(early == 0, "R3 no early clock", early, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(tgt_prog_b && tgt_cs_b && !tgt_cclk && !tgt_rdwr_b, "R1 reset pins",
              {tgt_prog_b, tgt_cs_b, tgt_cclk, tgt_rdwr_b}, 4'b1100);
        check(!run_busy && !done_ok && !crc_error && !timeout, "R1 reset status",
              {run_busy, done_ok, crc_error, timeout}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        for (int c = 0; c < 6; c++) begin
            run_case(c, int'(CASES[c][26:19]), CASES[c][18], int'(CASES[c][17:10]),
                     int'(CASES[c][9:2]), int'(CASES[c][1:0]));
            if (c == 0) begin
                check(raw_first == 8'h80, "R4 pin 0 is msb", raw_first, 8'h80);
                check(rise_c1 - rise_c0 == 2 * HALF, "R5 clock period", rise_c1 - rise_c0, 2 * HALF);
            end
        end

        // BUSY throttling
        busy_en = 1'b1;
        run_case(6, 8, 1'b0, 2, 0, 0);
        busy_en = 1'b0;
        check(blocked > 0, "R6 busy refused edges", blocked, 1);
        check(cap_n == 10, "R6 no loss or duplicate", cap_n, 10);

        summary_and_end();
    end
endmodule